// File: doc/BRIEF.md
# Integer ALU with NZCV Status Flags

This block is the integer execution unit of a small RISC core. In a single combinational pass it computes a 32-bit result from an operation code and two operands. It also produces the next negative, zero, carry and overflow flag values, plus a write-enable for the destination register.

A 4-bit status register inside the block holds the flags. It loads the next-flag value on a rising clock edge in two cases: when the core asks for a flag update, or when the operation is a compare or test form.

The operation set has three groups:
- Arithmetic: add and subtract, each with a carry-in variant.
- Reverse subtract: the operands are swapped before the subtraction.
- Logic: AND, OR, XOR, AND-NOT, move and move-inverted.

There are four flag-only forms. Two are arithmetic compares (subtract and add). Two are bit tests (AND and XOR). These forms never request a register write.

Multiplication and shifting are handled elsewhere in the core.

Top module: `alu_core`

## Requirements
- R1: `op_i` encoding is 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-carry, 4 reverse subtract, 5 reverse subtract-with-carry, 6 AND, 7 OR, 8 XOR, 9 AND-NOT, 10 move, 11 move-inverted, 12 compare, 13 compare-add, 14 test-AND, 15 test-XOR. Add computes A+B, and add-with-carry computes A+B+`carry_i`.
- R2: Subtract computes A+~B+1, and subtract-with-carry computes A+~B+`carry_i`. Reverse forms compute the same with A and B swapped. A carry-out of 1 means no borrow.
- R3: AND, OR and XOR combine A and B bitwise. AND-NOT gives A & ~B. Move gives B, and move-inverted gives ~B.
- R4: `flags_nxt_o` is {N,Z,C,V} with N at bit 3. N is bit 31 of the computed value, and Z is 1 exactly when the computed value is zero.
- R5: For the arithmetic and compare forms, C is the unsigned carry-out and V is signed two's-complement overflow. Two examples: -1 plus 1 gives 0 with flags 4'b0110, and 0x7FFFFFFF plus 1 gives 0x80000000 with flags 4'b1001.
- R6: For codes 6 to 11, 14 and 15, the next C and V equal the C and V currently held in `flags_o`.
- R7: For codes 12 to 15, `wr_en_o` is 0 and the flag register updates even when `set_flags_i` is 0. Compare computes A+~B+1, compare-add computes A+B, test-AND computes A&B, and test-XOR computes A^B. For codes 0 to 11, `wr_en_o` is 1.
- R8: On a rising edge, `flags_o` takes the value `flags_nxt_o` had if `set_flags_i` is 1 or the code is 12 to 15. Otherwise it holds.
- R9: While `rst_ni` is low, `flags_o` is 4'b0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| carry_i | input | 1 | Carry-in for the with-carry forms |
| set_flags_i | input | 1 | Request a flag update |
| result_o | output | 32 | Computed value |
| flags_nxt_o | output | 4 | Next {N,Z,C,V} |
| wr_en_o | output | 1 | Destination write enable |
| flags_o | output | 4 | Registered {N,Z,C,V} |

## Verification
Several properties are checked by assertions on every cycle:
- the status register holds whenever no update is requested, and loads the previous cycle's next-flag value whenever one is;
- flag-only forms never raise the write enable;
- logic forms carry C and V through unchanged;
- N and Z match every written result.

The bench's scenarios are needed for the rest. They show the arithmetic values themselves, the borrow sense of carry, signed overflow on the boundary operands, and the operand swap of the reverse forms. These are checked against a model that works on wide signed and unsigned integers.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_ADDC  = 4'd1,
    OP_SUB   = 4'd2,
    OP_SUBC  = 4'd3,
    OP_RSUB  = 4'd4,
    OP_RSUBC = 4'd5,
    OP_AND   = 4'd6,
    OP_OR    = 4'd7,
    OP_XOR   = 4'd8,
    OP_ANDN  = 4'd9,
    OP_MOVE  = 4'd10,
    OP_MOVEN = 4'd11,
    OP_CMPS  = 4'd12,
    OP_CMPA  = 4'd13,
    OP_TSTA  = 4'd14,
    OP_TSTX  = 4'd15
  } alu_op_e;

  localparam int unsigned FLAG_N = 3;
  localparam int unsigned FLAG_Z = 2;
  localparam int unsigned FLAG_C = 1;
  localparam int unsigned FLAG_V = 0;

  function automatic logic op_is_arith(alu_op_e op);
    return (op inside {OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_RSUB, OP_RSUBC,
                       OP_CMPS, OP_CMPA});
  endfunction

  function automatic logic op_flag_only(alu_op_e op);
    return (op inside {OP_CMPS, OP_CMPA, OP_TSTA, OP_TSTX});
  endfunction
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  alu_op_e          op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o,
  output logic             ovf_o
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH-1:0] x, y;
  logic             cin;
  logic [WIDTH:0]   full;

  // Subtraction folds into one adder: x + ~y + cin
  always_comb begin
    x   = a_i;
    y   = b_i;
    cin = 1'b0;
    unique case (op_i)
      OP_ADD, OP_CMPA: begin x = a_i; y = b_i;  cin = 1'b0;    end
      OP_ADDC:         begin x = a_i; y = b_i;  cin = carry_i; end
      OP_SUB, OP_CMPS: begin x = a_i; y = ~b_i; cin = 1'b1;    end
      OP_SUBC:         begin x = a_i; y = ~b_i; cin = carry_i; end
      OP_RSUB:         begin x = b_i; y = ~a_i; cin = 1'b1;    end
      OP_RSUBC:        begin x = b_i; y = ~a_i; cin = carry_i; end
      default:         begin x = a_i; y = b_i;  cin = 1'b0;    end
    endcase
  end

  assign full    = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
  assign sum_o   = full[MSB:0];
  assign carry_o = full[WIDTH];
  assign ovf_o   = (x[MSB] == y[MSB]) && (full[MSB] != x[MSB]);
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  alu_op_e          op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      OP_AND, OP_TSTA: res_o = a_i & b_i;
      OP_OR:           res_o = a_i | b_i;
      OP_XOR, OP_TSTX: res_o = a_i ^ b_i;
      OP_ANDN:         res_o = a_i & ~b_i;
      OP_MOVE:         res_o = b_i;
      OP_MOVEN:        res_o = ~b_i;
      default:         res_o = '0;
    endcase
  end
endmodule

// File: rtl/alu_flags.sv
module alu_flags #(
  parameter int unsigned NFLAGS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic [NFLAGS-1:0] flags_i,
  output logic [NFLAGS-1:0] flags_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flags_o <= '0;
    else if (upd_i) flags_o <= flags_i;
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [3:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             carry_i,
  input  logic             set_flags_i,
  output logic [WIDTH-1:0] result_o,
  output logic [3:0]       flags_nxt_o,
  output logic             wr_en_o,
  output logic [3:0]       flags_o
);
  localparam int unsigned MSB = WIDTH - 1;

  alu_op_e          op;
  logic [WIDTH-1:0] arith_res, logic_res;
  logic             arith_c, arith_v;
  logic             is_arith, flag_only;

  assign op        = alu_op_e'(op_i);
  assign is_arith  = op_is_arith(op);
  assign flag_only = op_flag_only(op);

  alu_addsub #(.WIDTH(WIDTH)) i_addsub (
    .op_i    (op),
    .a_i     (a_i),
    .b_i     (b_i),
    .carry_i (carry_i),
    .sum_o   (arith_res),
    .carry_o (arith_c),
    .ovf_o   (arith_v)
  );

  alu_logic #(.WIDTH(WIDTH)) i_logic (
    .op_i  (op),
    .a_i   (a_i),
    .b_i   (b_i),
    .res_o (logic_res)
  );

  assign result_o = is_arith ? arith_res : logic_res;
  assign wr_en_o  = ~flag_only;

  // Logic forms pass the held C and V through
  always_comb begin
    flags_nxt_o[FLAG_N] = result_o[MSB];
    flags_nxt_o[FLAG_Z] = (result_o == '0);
    flags_nxt_o[FLAG_C] = is_arith ? arith_c : flags_o[FLAG_C];
    flags_nxt_o[FLAG_V] = is_arith ? arith_v : flags_o[FLAG_V];
  end

  alu_flags #(.NFLAGS(4)) i_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .upd_i   (set_flags_i | flag_only),
    .flags_i (flags_nxt_o),
    .flags_o (flags_o)
  );

  a_r8_hold_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_flags_i && op_i[3:2] != 2'b11) |=> $stable(flags_o));

  a_r8_load_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_flags_i || op_i[3:2] == 2'b11) |=> (flags_o == $past(flags_nxt_o)));

  a_r7_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i[3:2] == 2'b11) |-> !wr_en_o);

  a_r6_keep_cv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i >= 4'd6 && op_i <= 4'd11) |-> (flags_nxt_o[1:0] == flags_o[1:0]));

  a_r4_nz_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (flags_nxt_o[3] == result_o[MSB] &&
                 flags_nxt_o[2] == (result_o == '0)));
endmodule

// File: tb/test_alu_core.sv
module test_alu_core;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op = '0;
  logic [31:0] a = '0, b = '0;
  logic        cin = 1'b0, sf = 1'b0;
  logic [31:0] result;
  logic [3:0]  flags_nxt, flags;
  logic        wr_en;

  int checks = 0;
  int fails  = 0;
  logic [3:0] fmodel = 4'b0000;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_core i_alu_core (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .a_i(a), .b_i(b),
    .carry_i(cin), .set_flags_i(sf), .result_o(result),
    .flags_nxt_o(flags_nxt), .wr_en_o(wr_en), .flags_o(flags)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Wide-integer model: x + y + ci, or x - y - (1 - ci)
  task automatic arith(input logic [31:0] x, input logic [31:0] y,
                       input logic ci, input bit subtract,
                       output logic [31:0] r, output logic c, output logic v);
    longint ux = longint'({32'd0, x});
    longint uy = longint'({32'd0, y});
    longint sx = longint'(signed'(x));
    longint sy = longint'(signed'(y));
    longint ur, sr;
    if (subtract) begin
      ur = ux - uy - (ci ? 0 : 1);
      sr = sx - sy - (ci ? 0 : 1);
      c  = (ur >= 0);
    end else begin
      ur = ux + uy + (ci ? 1 : 0);
      sr = sx + sy + (ci ? 1 : 0);
      c  = (ur > 64'sd4294967295);
    end
    v = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
    r = ur[31:0];
  endtask

  task automatic model(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y,
                       input logic ci, input logic [3:0] fq,
                       output logic [31:0] r, output logic [3:0] f, output logic we);
    logic c = fq[1], v = fq[0];
    case (o)
      4'd0:  arith(x, y, 1'b0, 0, r, c, v);
      4'd1:  arith(x, y, ci,   0, r, c, v);
      4'd2:  arith(x, y, 1'b1, 1, r, c, v);
      4'd3:  arith(x, y, ci,   1, r, c, v);
      4'd4:  arith(y, x, 1'b1, 1, r, c, v);
      4'd5:  arith(y, x, ci,   1, r, c, v);
      4'd6:  r = x & y;
      4'd7:  r = x | y;
      4'd8:  r = x ^ y;
      4'd9:  r = x & ~y;
      4'd10: r = y;
      4'd11: r = ~y;
      4'd12: arith(x, y, 1'b1, 1, r, c, v);
      4'd13: arith(x, y, 1'b0, 0, r, c, v);
      4'd14: r = x & y;
      default: r = x ^ y;
    endcase
    f  = {r[31], r == 32'd0, c, v};
    we = (o < 4'd12);
  endtask

  task automatic do_op(input string req, input logic [3:0] o, input logic [31:0] x,
                       input logic [31:0] y, input logic ci, input logic s);
    logic [31:0] er;
    logic [3:0]  ef;
    logic        ewe;
    @(negedge clk);
    op = o; a = x; b = y; cin = ci; sf = s;
    #1;
    model(o, x, y, ci, fmodel, er, ef, ewe);
    if (ewe) check(req, "result", result, er);
    check(req, "flags_nxt", {28'd0, flags_nxt}, {28'd0, ef});
    check("R7", "wr_en", {31'd0, wr_en}, {31'd0, ewe});
    if (s || o >= 4'd12) fmodel = ef;
    @(posedge clk); #1;
    check("R8", "flags", {28'd0, flags}, {28'd0, fmodel});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1 check("R9", "reset flags", {28'd0, flags}, 32'd0);
    @(negedge clk); rst_n = 1'b1;

    // R5 boundary examples
    do_op("R5", 4'd0, 32'hFFFF_FFFF, 32'd1, 1'b0, 1'b1);
    check("R5", "neg1 plus 1 flags", {28'd0, flags}, 32'h6);
    do_op("R5", 4'd0, 32'h7FFF_FFFF, 32'd1, 1'b0, 1'b1);
    check("R5", "max plus 1 flags", {28'd0, flags}, 32'h9);
    check("R5", "max plus 1 value", result, 32'h8000_0000);
    // R1 add with carry
    do_op("R1", 4'd1, 32'd10, 32'd20, 1'b1, 1'b0);
    check("R1", "adc value", result, 32'd31);
    // R2 subtract borrow sense, reverse swap
    do_op("R2", 4'd2, 32'd5, 32'd7, 1'b0, 1'b1);
    check("R2", "sub borrow C", {31'd0, flags[1]}, 32'd0);
    do_op("R2", 4'd4, 32'd5, 32'd7, 1'b0, 1'b1);
    check("R2", "rsub value", result, 32'd2);
    do_op("R2", 4'd3, 32'd9, 32'd4, 1'b0, 1'b0);
    do_op("R2", 4'd5, 32'd4, 32'd9, 1'b1, 1'b0);
    // R6 logic keeps C,V: set C=1,V=1 first
    do_op("R5", 4'd2, 32'h8000_0000, 32'd1, 1'b0, 1'b1);
    do_op("R6", 4'd9, 32'hF0F0_FFFF, 32'h00FF_000F, 1'b0, 1'b1);
    check("R6", "C,V kept", {30'd0, flags[1:0]}, 32'd3);
    do_op("R3", 4'd11, 32'd0, 32'h0000_FFFF, 1'b0, 1'b0);
    do_op("R3", 4'd10, 32'd0, 32'd0, 1'b0, 1'b1);
    // R7 flag-only forms update without set_flags
    do_op("R7", 4'd12, 32'd3, 32'd3, 1'b0, 1'b0);
    check("R7", "cmp equal Z,C", {28'd0, flags & 4'b0110}, 32'h6);
    do_op("R7", 4'd13, 32'hFFFF_FFFF, 32'd2, 1'b0, 1'b0);
    do_op("R7", 4'd14, 32'h0F, 32'hF0, 1'b0, 1'b0);
    do_op("R7", 4'd15, 32'h8000_0000, 32'd0, 1'b0, 1'b0);
    // R8 hold without request
    do_op("R8", 4'd0, 32'd0, 32'd0, 1'b0, 1'b0);
    // R4 mixed patterns
    for (int i = 0; i < 400; i++)
      do_op("R4", 4'($urandom_range(0, 15)), $urandom, (i % 7 == 0) ? 32'd0 : $urandom,
            1'($urandom), 1'($urandom));
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule